// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer that software must service inside a time window. A slow-clock enable pulse drives a prescaler. Each time the prescaler wraps, a down-counter loses one step. Software services the timer by writing a restart command that carries an 8-bit key. The restart is honoured only once the counter has fallen to or below a programmed window limit. A restart that arrives before that point is logged as an early-service error. A counter that runs down to zero is logged as an expiry. Either fault can drive an interrupt, a system reset request or a processor-only reset request.

The configuration word can be written once after reset. It holds the reload value, the window limit, the routing bits, a debug-freeze enable and a stop bit. A simple register port with word addresses 0 to 3 gives write access to the command and the configuration, and read access to the configuration, the fault flags and the live counter. The default parameters give a 12-bit counter and a divide-by-128 prescaler. With a 32.768 kHz enable rate, the counter steps at 256 Hz and the longest timeout is 16 s.

Top module: `win_watchdog`

## Requirements
- R1: After reset the counter reads all ones (0xFFF). The fault flags read 0 and all three fault outputs are low. The configuration (address 1) reads 0x0FFF2FFF: reload value 0xFFF in bits 11:0, window limit 0xFFF in bits 27:16, reset routing bit 13 set, all other bits 0.
- R2: While running, the counter (address 3, bits 11:0) drops by exactly one on every PRE_DIV-th slowTick pulse counted since the last reload, and holds otherwise.
- R3: When the counter steps from 1 to 0, the expiry flag (status bit 0) sets. The counter then stays at 0 until it is reloaded.
- R4: A write to address 0 with bit 0 set and bits 31:24 equal to 0xA5 is a restart. When the counter is at or below the window limit, the restart reloads the counter from the reload value and clears the prescaler.
- R5: A write to address 0 whose key byte is wrong, or whose bit 0 is clear, changes neither the counter nor the flags.
- R6: A restart while the counter is above the window limit sets the early-service flag (status bit 1) and leaves the counter unchanged.
- R7: Only the first write to address 1 after reset is taken. That write also reloads the counter from its bits 11:0 and clears the prescaler. Every later write to address 1 is ignored.
- R8: With the stop bit (bit 15) set, the counter does not move, restarts have no effect, and no flag sets.
- R9: With the debug-freeze enable (bit 28) set, the counter and prescaler hold while dbgHalt is high. With bit 28 clear, dbgHalt has no effect.
- R10: faultIrq is high while interrupt enable (bit 12) is set and either flag is set.
- R11: While reset routing (bit 13) is set and a flag is set, sysRstReq is high if processor-only (bit 14) is clear, and cpuRstReq is high if bit 14 is set. The two requests are never high together.
- R12: Reading address 2 with rdEn returns {early, expiry} in bits 1:0 and clears both flags at that clock edge. A flag that sets in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-cycle enable pulse at the slow clock rate |
| dbgHalt | input | 1 | Debugger halt indication |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears flags at address 2) |
| addr | input | 2 | Word address: 0 command, 1 configuration, 2 flags, 3 counter |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| faultIrq | output | 1 | Fault interrupt |
| sysRstReq | output | 1 | System reset request |
| cpuRstReq | output | 1 | Processor-only reset request |

## Verification
Several properties are checked on every cycle. The counter never rises except on a reload, it holds without a counted prescaler wrap, and it sticks at zero. The configuration stays frozen once written. A legal restart lands the reload value, an early restart raises its flag, and a stopped timer raises no flag. The two reset requests are never high together. Other behaviour shows only in the bench's scenarios. These are the exact step rate against the prescaler, where the window boundary sits at limit and limit plus one, the prescaler clearing on restart, key rejection, debug freeze, and routing to the right output.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;  // load counter from reloadVal, clear prescaler
    logic run;     // counting permitted this cycle
  } wdStrobe_t;

  typedef enum logic [1:0] {
    A_CMD  = 2'd0,
    A_CFG  = 2'd1,
    A_STAT = 2'd2,
    A_CNT  = 2'd3
  } wdAddr_t;

  localparam int unsigned CMD_GO_BIT   = 0;
  localparam int unsigned CMD_KEY_LSB  = 24;
  localparam int unsigned CFG_IRQ_BIT  = 12;
  localparam int unsigned CFG_RST_BIT  = 13;
  localparam int unsigned CFG_CPU_BIT  = 14;
  localparam int unsigned CFG_STOP_BIT = 15;
  localparam int unsigned CFG_LIM_LSB  = 16;
  localparam int unsigned CFG_HALT_BIT = 28;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned PRE_DIV = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strb,
  input  logic             slowTick,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);

  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic preWrap;
  logic stepEn;

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      assign preWrap = (preCnt == PRE_W'(PRE_DIV - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (strb.reload) begin
          preCnt <= '0;
        end else if (strb.run && slowTick) begin
          preCnt <= preWrap ? '0 : preCnt + PRE_W'(1);
        end
      end
    end else begin : g_nopre
      assign preWrap = 1'b1;
    end
  endgenerate

  assign stepEn  = !strb.reload && strb.run && slowTick && preWrap;
  assign expired = stepEn && (cnt == CNT_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '1;
    end else if (strb.reload) begin
      cnt <= reloadVal;
    end else if (stepEn && (cnt != '0)) begin
      cnt <= cnt - CNT_ONE;
    end
  end

  a_r2_never_rises : assert property (@(posedge clk) disable iff (!rstN)
    !strb.reload |=> (cnt <= $past(cnt)));

  a_r2_holds_idle : assert property (@(posedge clk) disable iff (!rstN)
    (!strb.reload && !(strb.run && slowTick)) |=> $stable(cnt));

  a_r3_zero_sticks : assert property (@(posedge clk) disable iff (!rstN)
    (!strb.reload && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter logic [7:0]  KEY   = 8'hA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  wdAddr_t          addr,
  input  logic [31:0]      wrData,
  input  logic             dbgHalt,
  input  logic [CNT_W-1:0] cnt,
  input  logic             expired,
  output wdStrobe_t        strb,
  output logic [CNT_W-1:0] reloadVal,
  output logic [31:0]      cfgReg,
  output logic [1:0]       statFlags,
  output logic             faultIrq,
  output logic             sysRstReq,
  output logic             cpuRstReq
);

  localparam logic [31:0] FIELD_ONES = 32'((64'd1 << CNT_W) - 64'd1);
  localparam logic [31:0] CFG_MASK   = FIELD_ONES
                                     | (FIELD_ONES << CFG_LIM_LSB)
                                     | (32'd1 << CFG_IRQ_BIT)
                                     | (32'd1 << CFG_RST_BIT)
                                     | (32'd1 << CFG_CPU_BIT)
                                     | (32'd1 << CFG_STOP_BIT)
                                     | (32'd1 << CFG_HALT_BIT);
  localparam logic [31:0] CFG_RESET  = FIELD_ONES
                                     | (FIELD_ONES << CFG_LIM_LSB)
                                     | (32'd1 << CFG_RST_BIT);

  logic             cfgLocked;
  logic             errFlag;
  logic             expFlag;
  logic             cfgWr;
  logic             cmdWr;
  logic             stopped;
  logic             restartReq;
  logic             earlyHit;
  logic             legalHit;
  logic             statRd;
  logic             anyFault;
  logic [CNT_W-1:0] cfgVal;
  logic [CNT_W-1:0] cfgLim;

  assign cfgVal  = cfgReg[CNT_W-1:0];
  assign cfgLim  = cfgReg[CFG_LIM_LSB +: CNT_W];
  assign stopped = cfgReg[CFG_STOP_BIT];

  assign cfgWr      = wrEn && (addr == A_CFG) && !cfgLocked;
  assign cmdWr      = wrEn && (addr == A_CMD);
  assign restartReq = cmdWr && wrData[CMD_GO_BIT]
                      && (wrData[CMD_KEY_LSB +: 8] == KEY) && !stopped;
  assign earlyHit   = restartReq && (cnt > cfgLim);
  assign legalHit   = restartReq && !earlyHit;
  assign statRd     = rdEn && (addr == A_STAT);

  assign strb.reload = cfgWr || legalHit;
  assign strb.run    = !stopped && !(cfgReg[CFG_HALT_BIT] && dbgHalt);
  assign reloadVal   = cfgWr ? wrData[CNT_W-1:0] : cfgVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg    <= CFG_RESET;
      cfgLocked <= 1'b0;
    end else if (cfgWr) begin
      cfgReg    <= wrData & CFG_MASK;
      cfgLocked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      expFlag <= 1'b0;
    end else begin
      if (earlyHit)      errFlag <= 1'b1;
      else if (statRd)   errFlag <= 1'b0;
      if (expired && !stopped) expFlag <= 1'b1;
      else if (statRd)         expFlag <= 1'b0;
    end
  end

  assign statFlags = {errFlag, expFlag};
  assign anyFault  = errFlag || expFlag;
  assign faultIrq  = cfgReg[CFG_IRQ_BIT] && anyFault;
  assign sysRstReq = cfgReg[CFG_RST_BIT] && !cfgReg[CFG_CPU_BIT] && anyFault;
  assign cpuRstReq = cfgReg[CFG_RST_BIT] &&  cfgReg[CFG_CPU_BIT] && anyFault;

  a_r7_cfg_frozen : assert property (@(posedge clk) disable iff (!rstN)
    cfgLocked |=> $stable(cfgReg));

  a_r4_legal_reload : assert property (@(posedge clk) disable iff (!rstN)
    legalHit |=> (cnt == $past(cfgVal)));

  a_r6_early_flags : assert property (@(posedge clk) disable iff (!rstN)
    earlyHit |=> errFlag);

  a_r8_stopped_quiet : assert property (@(posedge clk) disable iff (!rstN)
    (cfgLocked && stopped && !errFlag && !expFlag) |=> (!errFlag && !expFlag));

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned PRE_DIV = 128,
  parameter logic [7:0]  KEY     = 8'hA5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        slowTick,
  input  logic        dbgHalt,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        faultIrq,
  output logic        sysRstReq,
  output logic        cpuRstReq
);

  wdStrobe_t        strb;
  wdAddr_t          addrT;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reloadVal;
  logic             expired;
  logic [31:0]      cfgReg;
  logic [1:0]       statFlags;

  assign addrT = wdAddr_t'(addr);

  wdog_ctrl #(.CNT_W(CNT_W), .KEY(KEY)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addrT),
    .wrData    (wrData),
    .dbgHalt   (dbgHalt),
    .cnt       (cnt),
    .expired   (expired),
    .strb      (strb),
    .reloadVal (reloadVal),
    .cfgReg    (cfgReg),
    .statFlags (statFlags),
    .faultIrq  (faultIrq),
    .sysRstReq (sysRstReq),
    .cpuRstReq (cpuRstReq)
  );

  wdog_datapath #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .slowTick  (slowTick),
    .reloadVal (reloadVal),
    .cnt       (cnt),
    .expired   (expired)
  );

  always_comb begin
    unique case (addrT)
      A_CFG:   rdData = cfgReg;
      A_STAT:  rdData = {30'd0, statFlags};
      A_CNT:   rdData = 32'(cnt);
      default: rdData = '0;
    endcase
  end

  a_r11_one_target : assert property (@(posedge clk) disable iff (!rstN)
    !(sysRstReq && cpuRstReq));

endmodule

// File: tb/win_watchdog_test.sv
module win_watchdog_test;

  localparam int CLK_PERIOD = 10;
  localparam int PDIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b0;
  logic        dbgHalt = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        faultIrq, sysRstReq, cpuRstReq;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_watchdog #(.CNT_W(12), .PRE_DIV(PDIV), .KEY(8'hA5)) uut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .dbgHalt(dbgHalt),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .faultIrq(faultIrq), .sysRstReq(sysRstReq),
    .cpuRstReq(cpuRstReq)
  );

  function automatic logic [31:0] cfgWord(int v, int lim, bit irq, bit rst,
                                          bit cpu, bit stop, bit halt);
    return 32'(v & 12'hFFF) | (32'(lim & 12'hFFF) << 16) | (32'(irq) << 12)
         | (32'(rst) << 13) | (32'(cpu) << 14) | (32'(stop) << 15)
         | (32'(halt) << 28);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; dbgHalt = 1'b0; slowTick = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1 wrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(posedge clk); #1 rdEn = 1'b0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slowTick = 1'b1;
      @(posedge clk); #1 slowTick = 1'b0;
    end
  endtask

  task automatic peek(output logic [31:0] d);
    @(negedge clk); addr = 2'd3; #1 d = rdData;
  endtask

  initial begin
    logic [31:0] d;
    doReset();

    // R1 reset state
    rd(2'd3, d); chk("R1 counter", d, 32'hFFF);
    rd(2'd1, d); chk("R1 config", d, 32'h0FFF2FFF);
    rd(2'd2, d); chk("R1 flags", d, 0);
    chk("R1 outputs", {faultIrq, sysRstReq, cpuRstReq}, 0);

    // R2 step rate sweep
    for (int k = 1; k <= 40; k++) begin
      tick(1);
      peek(d); chk("R2 step", d, 32'(12'hFFF - k / PDIV));
    end

    // R9 dbgHalt without freeze enable has no effect
    doReset();
    dbgHalt = 1'b1; tick(PDIV);
    peek(d); chk("R9 halt ignored", d, 32'hFFE);
    dbgHalt = 1'b0;

    // R7 first config write loads counter
    doReset();
    wr(2'd1, cfgWord(20, 10, 1, 1, 0, 0, 0));
    peek(d); chk("R7 load", d, 20);
    wr(2'd1, cfgWord(30, 5, 0, 0, 1, 1, 1));
    rd(2'd1, d); chk("R7 second write ignored", d, cfgWord(20, 10, 1, 1, 0, 0, 0));
    peek(d); chk("R7 counter kept", d, 20);

    // R6 early restart
    wr(2'd0, 32'hA500_0001);
    peek(d); chk("R6 counter unchanged", d, 20);
    chk("R10 irq", faultIrq, 1);
    chk("R11 sys req", {sysRstReq, cpuRstReq}, 2'b10);
    rd(2'd2, d); chk("R6 err flag", d, 2);
    rd(2'd2, d); chk("R12 cleared", d, 0);
    chk("R12 irq dropped", faultIrq, 0);

    // R5 rejected commands
    tick(12 * PDIV);
    peek(d); chk("R5 pre", d, 8);
    wr(2'd0, 32'h5A00_0001);
    wr(2'd0, 32'hA500_0000);
    peek(d); chk("R5 counter", d, 8);
    rd(2'd2, d); chk("R5 flags", d, 0);

    // R4 legal restart clears prescaler
    tick(2);
    wr(2'd0, 32'hA500_0001);
    peek(d); chk("R4 reload", d, 20);
    tick(PDIV - 1);
    peek(d); chk("R4 prescaler cleared", d, 20);
    tick(1);
    peek(d); chk("R4 first step", d, 19);

    // R3 expiry
    tick(19 * PDIV);
    peek(d); chk("R3 zero", d, 0);
    chk("R10 irq expiry", faultIrq, 1);
    tick(2 * PDIV);
    peek(d); chk("R3 stays zero", d, 0);
    rd(2'd2, d); chk("R3 expiry flag", d, 1);

    // R4/R6 window boundary sweep over every counter position
    for (int c = 20; c >= 0; c--) begin
      doReset();
      wr(2'd1, cfgWord(20, 10, 1, 1, 0, 0, 0));
      tick((20 - c) * PDIV);
      wr(2'd0, 32'hA500_0001);
      peek(d);
      chk(c <= 10 ? "R4 window legal" : "R6 window early", d, (c <= 10) ? 20 : c);
      rd(2'd2, d);
      chk("R6 window flags", d, ((c > 10) ? 2 : 0) | ((c == 0) ? 1 : 0));
    end

    // R11 processor-only routing, irq disabled
    doReset();
    wr(2'd1, cfgWord(20, 10, 0, 1, 1, 0, 0));
    wr(2'd0, 32'hA500_0001);
    chk("R11 cpu req", {faultIrq, sysRstReq, cpuRstReq}, 3'b001);

    // R11 routing off
    doReset();
    wr(2'd1, cfgWord(20, 10, 0, 0, 0, 0, 0));
    wr(2'd0, 32'hA500_0001);
    chk("R11 no routing", {faultIrq, sysRstReq, cpuRstReq}, 3'b000);
    rd(2'd2, d); chk("R11 flag still set", d, 2);

    // R8 stopped
    doReset();
    wr(2'd1, cfgWord(3, 1, 1, 1, 0, 1, 0));
    tick(5 * PDIV);
    peek(d); chk("R8 no count", d, 3);
    wr(2'd0, 32'hA500_0001);
    rd(2'd2, d); chk("R8 no flags", d, 0);
    chk("R8 outputs", {faultIrq, sysRstReq, cpuRstReq}, 0);

    // R9 debug freeze
    doReset();
    wr(2'd1, cfgWord(20, 10, 0, 0, 0, 0, 1));
    dbgHalt = 1'b1; tick(2 * PDIV);
    peek(d); chk("R9 frozen", d, 20);
    dbgHalt = 1'b0; tick(PDIV);
    peek(d); chk("R9 resumed", d, 19);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog timeout actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

endmodule